// File: doc/BRIEF.md
# Radio Byte Port with Sticky Error States

This block is the single-byte data window between a processor or DMA bus and the serial bit engine of a packet radio. In receive operation it captures each byte the radio delivers and holds it until the bus reads it. In transmit operation it holds the byte the bus wrote until the radio asks for it. The holding register behaves as a one-entry queue. A `full` bit records whether it currently holds an unconsumed byte.

Two misuse cases are caught. In the first, a received byte arrives while the previous byte has not been read. In the second, the radio asks for a byte while none is held. Either case locks the port into an error state. In the error state radio transfers and data writes are ignored and the held byte is frozen. Only the idle command strobe releases the port. The same strobe loads the operating direction from `mode_sel` and empties the buffer.

Eight sticky event flags feed one level interrupt through a per-event enable mask. Six of the flags come from radio-side event pulses and two come from the error detectors. A one-cycle DMA request pulse marks every point at which a byte becomes ready to read or a slot becomes free to write.

Top module: `radio_byte_port`

## Requirements
- R1: After reset the mask register and flag register read 0. The status register reads 0, meaning receive direction, empty buffer and running state. `irq` and `dma_req` are low.
- R2: In receive direction, a byte is captured when `rf_rx_valid` is high and the buffer is empty. It reads back at address 0. A data read empties the buffer. `dma_req` is high for the one cycle after the capture edge.
- R3: In receive direction, a new byte that arrives while the buffer is full, with no data read in the same cycle, enters the receive-overrun state. That state has code 1 in status bits [3:2]. It sets flag bit 6 and flag bit 4. When a data read and a new byte occur in the same cycle, the read returns the old byte, the new byte is captured and no error results.
- R4: In transmit direction, a data write at address 0 loads the buffer and sets `full`. When `rf_tx_req` is high and the buffer is full, the held byte appears on `rf_tx_byte` in that cycle and the buffer empties. `dma_req` then pulses in the next cycle.
- R5: In transmit direction, `rf_tx_req` with an empty buffer enters the transmit-starved state. That state has code 2 in status bits [3:2]. It sets flag bit 7 and flag bit 4.
- R6: In either error state, radio bytes, radio requests and data writes have no effect. Data reads do not empty the buffer. The held byte, `full` and the state all stay unchanged until the idle strobe.
- R7: `idle_strobe` returns the port to the running state and clears `full`. It loads the direction from `mode_sel` (1 = transmit), which status bit 0 reports. It takes priority over every other input in its cycle. Entering transmit direction pulses `dma_req` in the next cycle.
- R8: Flags at address 2 are sticky. Writing 1 to a bit clears that bit. When a flag is set and cleared in the same cycle, the set wins. The idle strobe does not clear flags.
- R9: The mask at address 1 has its bits ordered from MSB to LSB as transmit starved, receive overrun, receive timeout, packet done, carrier sense, preamble quality, clear channel and sync found. A mask bit of 1 enables its event. `irq` is the OR over all eight bits of flag AND mask.
- R10: `ext_evt[5:0]` pulses set flag bits 5 to 0 in the same order: timeout, packet done, carrier sense, preamble quality, clear channel and sync found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe (reads of address 0 have a side effect) |
| bus_addr | input | 2 | Register select: 0 data, 1 mask, 2 flags, 3 status |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data (combinational) |
| idle_strobe | input | 1 | Idle command: leave error state, empty buffer, load direction |
| mode_sel | input | 1 | Direction loaded at the idle strobe (1 = transmit) |
| rf_rx_valid | input | 1 | Radio delivers a received byte |
| rf_rx_byte | input | 8 | Received byte from the radio |
| rf_tx_req | input | 1 | Radio requests the next byte to send |
| rf_tx_byte | output | 8 | Byte offered to the radio |
| ext_evt | input | 6 | Radio event pulses for flag bits 5 to 0 |
| irq | output | 1 | Masked interrupt request |
| dma_req | output | 1 | One-cycle DMA trigger pulse |

## Verification
A wrong `full` bit or state code shows on the status register as soon as the next bus read. It also shows one edge later as a spurious or missing overrun or starvation flag. A buffer corrupted during an error state shows when address 0 is read after the idle strobe. A wrong mask or flag bit shows on `irq` in the cycle after the event edge. A misplaced DMA pulse shows exactly one cycle after the capture, consume or idle edge. So every fault the bench targets shows at the ports within two cycles of the stimulus that triggers it.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

    localparam int BYTE_W  = 8;
    localparam int NUM_EVT = 8;
    localparam int NUM_EXT = 6;
    localparam int ADDR_W  = 2;

    // Register select codes
    localparam logic [ADDR_W-1:0] ADR_DATA   = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_MASK   = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_FLAGS  = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_STATUS = 2'd3;

    // Flag / mask bit positions (order is visible to software)
    localparam int FL_TXSTARVE = 7;
    localparam int FL_RXOVER   = 6;
    localparam int FL_TIMEOUT  = 5;
    localparam int FL_PKTDONE  = 4;
    localparam int FL_CARRIER  = 3;
    localparam int FL_PREAMBLE = 2;
    localparam int FL_CLEARCH  = 1;
    localparam int FL_SYNC     = 0;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_RXOVER = 2'd1,
        ST_TXSTRV = 2'd2
    } port_state_t;

    typedef struct packed {
        logic                wr_data;
        logic                rd_data;
        logic                wr_mask;
        logic                clr_flags;
    } bus_dec_t;

    // Merge radio event pulses with the error detectors into the set vector
    function automatic logic [NUM_EVT-1:0] event_set(
        input logic [NUM_EXT-1:0] ext,
        input logic               over,
        input logic               starve
    );
        logic [NUM_EVT-1:0] s;
        s                = '0;
        s[NUM_EXT-1:0]   = ext;
        s[FL_RXOVER]     = over;
        s[FL_TXSTARVE]   = starve;
        s[FL_PKTDONE]    = ext[FL_PKTDONE] | over | starve;
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(
        input port_state_t st,
        input logic        full,
        input logic        tx_dir
    );
        return {{(BYTE_W-4){1'b0}}, st, full, tx_dir};
    endfunction

endpackage

// File: rtl/rbp_busif.sv
module rbp_busif
    import rbp_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W
) (
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] data_q,
    input  logic [DW-1:0] mask_q,
    input  logic [DW-1:0] flags_q,
    input  logic [DW-1:0] status_q,
    output bus_dec_t      dec,
    output logic [DW-1:0] rdata
);

    always_comb begin
        dec.wr_data   = bus_wr && (bus_addr == ADR_DATA);
        dec.rd_data   = bus_rd && (bus_addr == ADR_DATA);
        dec.wr_mask   = bus_wr && (bus_addr == ADR_MASK);
        dec.clr_flags = bus_wr && (bus_addr == ADR_FLAGS);
    end

    always_comb begin
        unique case (bus_addr)
            ADR_DATA:   rdata = data_q;
            ADR_MASK:   rdata = mask_q;
            ADR_FLAGS:  rdata = flags_q;
            default:    rdata = status_q;
        endcase
    end

endmodule

// File: rtl/rbp_buffer.sv
module rbp_buffer
    import rbp_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          idle,
    input  logic          mode_sel,
    input  logic          wr_data,
    input  logic          rd_data,
    input  logic [DW-1:0] wdata,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic          tx_req,
    output logic [DW-1:0] buf_q,
    output logic          full_q,
    output logic          tx_dir_q,
    output port_state_t   state_q,
    output logic          over_evt,
    output logic          starve_evt,
    output logic          dma_q
);

    port_state_t   state_n;
    logic [DW-1:0] buf_n;
    logic          full_n;
    logic          tx_dir_n;
    logic          dma_n;

    always_comb begin
        state_n    = state_q;
        buf_n      = buf_q;
        full_n     = full_q;
        tx_dir_n   = tx_dir_q;
        dma_n      = 1'b0;
        over_evt   = 1'b0;
        starve_evt = 1'b0;
        if (idle) begin
            state_n  = ST_RUN;
            full_n   = 1'b0;
            tx_dir_n = mode_sel;
            dma_n    = mode_sel;
        end else if (state_q == ST_RUN) begin
            if (!tx_dir_q) begin
                if (rx_valid) begin
                    if (full_q && !rd_data) begin
                        state_n  = ST_RXOVER;
                        over_evt = 1'b1;
                    end else begin
                        buf_n  = rx_byte;
                        full_n = 1'b1;
                        dma_n  = 1'b1;
                    end
                end else if (rd_data) begin
                    full_n = 1'b0;
                end
            end else begin
                if (tx_req) begin
                    if (full_q) begin
                        dma_n = 1'b1;
                        if (wr_data) begin
                            buf_n  = wdata;
                            full_n = 1'b1;
                        end else begin
                            full_n = 1'b0;
                        end
                    end else begin
                        state_n    = ST_TXSTRV;
                        starve_evt = 1'b1;
                    end
                end else if (wr_data) begin
                    buf_n  = wdata;
                    full_n = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RUN;
            buf_q    <= '0;
            full_q   <= 1'b0;
            tx_dir_q <= 1'b0;
            dma_q    <= 1'b0;
        end else begin
            state_q  <= state_n;
            buf_q    <= buf_n;
            full_q   <= full_n;
            tx_dir_q <= tx_dir_n;
            dma_q    <= dma_n;
        end
    end

    // R3: an unread byte followed by a new arrival locks the receive-overrun state
    a_r3_overrun_enter: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !tx_dir_q && rx_valid && full_q && !rd_data && !idle)
        |=> (state_q == ST_RXOVER));

    // R5: a request against an empty buffer locks the starved state
    a_r5_starve_enter: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && tx_dir_q && tx_req && !full_q && !idle)
        |=> (state_q == ST_TXSTRV));

    // R6: the held byte never moves while an error state is active
    a_r6_byte_frozen: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_RUN) |=> $stable(buf_q));

    // R6: the error state persists until the idle strobe
    a_r6_state_held: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_RUN && !idle) |=> $stable(state_q) && $stable(full_q));

    // R7: the idle strobe always empties the buffer and resumes running
    a_r7_idle_release: assert property (@(posedge clk) disable iff (rst)
        idle |=> (state_q == ST_RUN) && !full_q);

endmodule

// File: rtl/rbp_irq.sv
module rbp_irq
    import rbp_pkg::*;
#(
    parameter int NE = NUM_EVT,
    parameter int NX = NUM_EXT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NX-1:0] ext_evt,
    input  logic          over_evt,
    input  logic          starve_evt,
    input  logic          wr_mask,
    input  logic          clr_flags,
    input  logic [NE-1:0] wdata,
    output logic [NE-1:0] mask_q,
    output logic [NE-1:0] flags_q,
    output logic          irq
);

    logic [NE-1:0] set_v;

    always_comb set_v = event_set(ext_evt, over_evt, starve_evt);

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (wr_mask) mask_q <= wdata;
    end

    for (genvar i = 0; i < NE; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) flags_q[i] <= 1'b0;
            else     flags_q[i] <= set_v[i] | (flags_q[i] & ~(clr_flags & wdata[i]));
        end

        // R8: a flag is dropped only by a write-1-to-clear of its bit
        a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
            (flags_q[i] && !(clr_flags && wdata[i])) |=> flags_q[i]);
    end

    always_comb irq = |(flags_q & mask_q);

    // R9: an enabled event raises the interrupt one edge later
    a_r9_enabled_raises: assert property (@(posedge clk) disable iff (rst)
        (|(set_v & mask_q) && !wr_mask) |=> irq);

endmodule

// File: rtl/radio_byte_port.sv
module radio_byte_port
    import rbp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              idle_strobe,
    input  logic              mode_sel,
    input  logic              rf_rx_valid,
    input  logic [BYTE_W-1:0] rf_rx_byte,
    input  logic              rf_tx_req,
    output logic [BYTE_W-1:0] rf_tx_byte,
    input  logic [NUM_EXT-1:0] ext_evt,
    output logic              irq,
    output logic              dma_req
);

    bus_dec_t          dec;
    logic [BYTE_W-1:0] buf_q;
    logic [BYTE_W-1:0] mask_q;
    logic [BYTE_W-1:0] flags_q;
    logic [BYTE_W-1:0] status_q;
    logic              full_q;
    logic              tx_dir_q;
    port_state_t       state_q;
    logic              over_evt;
    logic              starve_evt;

    always_comb status_q   = pack_status(state_q, full_q, tx_dir_q);
    always_comb rf_tx_byte = buf_q;

    rbp_busif #(.AW(ADDR_W), .DW(BYTE_W)) u_busif (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .data_q   (buf_q),
        .mask_q   (mask_q),
        .flags_q  (flags_q),
        .status_q (status_q),
        .dec      (dec),
        .rdata    (bus_rdata)
    );

    rbp_buffer #(.DW(BYTE_W)) u_buffer (
        .clk        (clk),
        .rst        (rst),
        .idle       (idle_strobe),
        .mode_sel   (mode_sel),
        .wr_data    (dec.wr_data),
        .rd_data    (dec.rd_data),
        .wdata      (bus_wdata),
        .rx_valid   (rf_rx_valid),
        .rx_byte    (rf_rx_byte),
        .tx_req     (rf_tx_req),
        .buf_q      (buf_q),
        .full_q     (full_q),
        .tx_dir_q   (tx_dir_q),
        .state_q    (state_q),
        .over_evt   (over_evt),
        .starve_evt (starve_evt),
        .dma_q      (dma_req)
    );

    rbp_irq #(.NE(NUM_EVT), .NX(NUM_EXT)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .ext_evt    (ext_evt),
        .over_evt   (over_evt),
        .starve_evt (starve_evt),
        .wr_mask    (dec.wr_mask),
        .clr_flags  (dec.clr_flags),
        .wdata      (bus_wdata),
        .mask_q     (mask_q),
        .flags_q    (flags_q),
        .irq        (irq)
    );

endmodule

// File: tb/radio_byte_port_tb.sv
module radio_byte_port_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_wr, bus_rd;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       idle_strobe, mode_sel;
    logic       rf_rx_valid, rf_tx_req;
    logic [7:0] rf_rx_byte, rf_tx_byte;
    logic [5:0] ext_evt;
    logic       irq, dma_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    radio_byte_port u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .idle_strobe(idle_strobe), .mode_sel(mode_sel),
        .rf_rx_valid(rf_rx_valid), .rf_rx_byte(rf_rx_byte),
        .rf_tx_req(rf_tx_req), .rf_tx_byte(rf_tx_byte),
        .ext_evt(ext_evt), .irq(irq), .dma_req(dma_req)
    );

    // Ops: 0 write, 1 read+check, 2 radio byte, 3 radio request+check,
    //      4 radio request no check, 5 idle (data[0]=mode), 6 events, 7 irq check
    localparam int NV = 39;
    localparam logic [24:0] VECS [0:NV-1] = '{
        {3'd1, 2'd3, 8'h00, 8'h00, 4'd1},   // R1 status after reset
        {3'd1, 2'd1, 8'h00, 8'h00, 4'd1},   // R1 mask after reset
        {3'd2, 2'd0, 8'hA5, 8'h00, 4'd2},   // R2 byte arrives
        {3'd1, 2'd3, 8'h00, 8'h02, 4'd2},   // R2 full set
        {3'd1, 2'd0, 8'h00, 8'hA5, 4'd2},   // R2 read byte
        {3'd1, 2'd3, 8'h00, 8'h00, 4'd2},   // R2 read emptied buffer
        {3'd2, 2'd0, 8'h3C, 8'h00, 4'd3},   // R3 first byte
        {3'd2, 2'd0, 8'h77, 8'h00, 4'd3},   // R3 unread -> overrun
        {3'd1, 2'd3, 8'h00, 8'h06, 4'd3},   // R3 state code 1, full
        {3'd1, 2'd2, 8'h00, 8'h50, 4'd3},   // R3 flags 6 and 4
        {3'd2, 2'd0, 8'h11, 8'h00, 4'd6},   // R6 ignored byte
        {3'd1, 2'd0, 8'h00, 8'h3C, 4'd6},   // R6 byte frozen
        {3'd1, 2'd3, 8'h00, 8'h06, 4'd6},   // R6 read did not empty
        {3'd5, 2'd0, 8'h01, 8'h00, 4'd7},   // R7 idle into transmit
        {3'd1, 2'd3, 8'h00, 8'h01, 4'd7},   // R7 running, empty, transmit
        {3'd0, 2'd0, 8'h5A, 8'h00, 4'd4},   // R4 write byte
        {3'd1, 2'd3, 8'h00, 8'h03, 4'd4},   // R4 full
        {3'd3, 2'd0, 8'h00, 8'h5A, 4'd4},   // R4 radio takes byte
        {3'd1, 2'd3, 8'h00, 8'h01, 4'd4},   // R4 emptied
        {3'd0, 2'd2, 8'hFF, 8'h00, 4'd8},   // R8 clear all flags
        {3'd1, 2'd2, 8'h00, 8'h00, 4'd8},   // R8 flags cleared
        {3'd4, 2'd0, 8'h00, 8'h00, 4'd5},   // R5 request on empty
        {3'd1, 2'd3, 8'h00, 8'h09, 4'd5},   // R5 state code 2
        {3'd1, 2'd2, 8'h00, 8'h90, 4'd5},   // R5 flags 7 and 4
        {3'd0, 2'd0, 8'h99, 8'h00, 4'd6},   // R6 write ignored
        {3'd1, 2'd3, 8'h00, 8'h09, 4'd6},   // R6 still empty
        {3'd0, 2'd1, 8'h80, 8'h00, 4'd9},   // R9 enable starvation
        {3'd7, 2'd0, 8'h00, 8'h01, 4'd9},   // R9 irq high
        {3'd0, 2'd1, 8'h40, 8'h00, 4'd9},   // R9 enable overrun only
        {3'd7, 2'd0, 8'h00, 8'h00, 4'd9},   // R9 irq low
        {3'd5, 2'd0, 8'h00, 8'h00, 4'd7},   // R7 idle into receive
        {3'd1, 2'd3, 8'h00, 8'h00, 4'd7},   // R7 status clean
        {3'd1, 2'd2, 8'h00, 8'h90, 4'd8},   // R8 idle kept flags
        {3'd0, 2'd2, 8'h10, 8'h00, 4'd8},   // R8 clear bit 4
        {3'd1, 2'd2, 8'h00, 8'h80, 4'd8},   // R8 only bit 4 gone
        {3'd6, 2'd0, 8'h2A, 8'h00, 4'd10},  // R10 timeout, carrier, clear channel
        {3'd1, 2'd2, 8'h00, 8'hAA, 4'd10},  // R10 flags 5,3,1 added
        {3'd0, 2'd1, 8'h01, 8'h00, 4'd9},   // R9 enable sync only
        {3'd6, 2'd0, 8'h01, 8'h00, 4'd10}   // R10 sync event
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic quiet();
        bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        idle_strobe = 0; mode_sel = 0; rf_rx_valid = 0; rf_rx_byte = 0;
        rf_tx_req = 0; ext_evt = 0;
    endtask

    task automatic run_vec(input logic [24:0] v);
        logic [2:0] op;
        logic [1:0] ad;
        logic [7:0] dt, ex;
        string      rq;
        op = v[24:22]; ad = v[21:20]; dt = v[19:12]; ex = v[11:4];
        rq = $sformatf("R%0d", v[3:0]);
        case (op)
            3'd0: begin bus_wr = 1; bus_addr = ad; bus_wdata = dt; end
            3'd1: begin bus_rd = 1; bus_addr = ad; end
            3'd2: begin rf_rx_valid = 1; rf_rx_byte = dt; end
            3'd3, 3'd4: rf_tx_req = 1;
            3'd5: begin idle_strobe = 1; mode_sel = dt[0]; end
            3'd6: ext_evt = dt[5:0];
            default: ;
        endcase
        #2;
        if (op == 3'd1) check(bus_rdata, ex, rq);
        if (op == 3'd3) check(rf_tx_byte, ex, rq);
        if (op == 3'd7) check({7'd0, irq}, ex, rq);
        @(negedge clk);
        quiet();
    endtask

    task automatic read_chk(input logic [1:0] ad, input logic [7:0] ex, input string rq);
        bus_rd = 1; bus_addr = ad;
        #2 check(bus_rdata, ex, rq);
        @(negedge clk);
        quiet();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        quiet();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: outputs idle after reset
        check({7'd0, irq}, 8'h00, "R1 irq");
        check({7'd0, dma_req}, 8'h00, "R1 dma_req");

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);
        // R10 / R9: sync event with sync enabled raises irq
        check({7'd0, irq}, 8'h01, "R10 sync irq");

        // R2: DMA pulse one cycle after a capture
        idle_strobe = 1; mode_sel = 0;
        @(negedge clk); quiet();
        check({7'd0, dma_req}, 8'h00, "R7 no dma entering receive");
        rf_rx_valid = 1; rf_rx_byte = 8'h12;
        @(negedge clk); quiet();
        check({7'd0, dma_req}, 8'h01, "R2 dma after capture");
        @(negedge clk);
        check({7'd0, dma_req}, 8'h00, "R2 dma single cycle");

        // R3: same-cycle read and arrival is not an overrun
        rf_rx_valid = 1; rf_rx_byte = 8'h34; bus_rd = 1; bus_addr = 2'd0;
        #2 check(bus_rdata, 8'h12, "R3 old byte on same-cycle read");
        @(negedge clk); quiet();
        read_chk(2'd3, 8'h02, "R3 no overrun on same-cycle read");
        read_chk(2'd0, 8'h34, "R3 new byte captured");

        // R7: entering transmit pulses dma_req
        idle_strobe = 1; mode_sel = 1;
        @(negedge clk); quiet();
        check({7'd0, dma_req}, 8'h01, "R7 dma entering transmit");

        // R4: consume pulses dma_req
        bus_wr = 1; bus_addr = 2'd0; bus_wdata = 8'hC3;
        @(negedge clk); quiet();
        rf_tx_req = 1;
        #2 check(rf_tx_byte, 8'hC3, "R4 byte offered");
        @(negedge clk); quiet();
        check({7'd0, dma_req}, 8'h01, "R4 dma after consume");

        // R8: set wins over clear in the same cycle
        bus_wr = 1; bus_addr = 2'd2; bus_wdata = 8'h08; ext_evt = 6'h08;
        @(negedge clk); quiet();
        read_chk(2'd2, 8'hAB, "R8 set beats clear");

        // R7: idle strobe wins over a same-cycle radio request
        idle_strobe = 1; mode_sel = 1; rf_tx_req = 1;
        @(negedge clk); quiet();
        read_chk(2'd3, 8'h01, "R7 idle priority");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule